// File: doc/BRIEF.md
# Programmable Output Rounding Unit

This unit sits after the accumulator of a fixed-point FIR filter. It takes the 28-bit fractional result and rounds it at a bit weight chosen at run time. It keeps only the most significant bits that remain valid at that precision. Bit 18 of the word carries weight 2^0, so bits 27..18 form the integer part and bits 17..0 hold the fractions 2^-1 down to 2^-18.

A 4-bit position code picks one of twelve weights, from 2^-10 up to 2^1. The unit adds a single 1 at that weight and then clears every bit at or below it. An unused code leaves the word untouched. The sum wraps; it is never saturated.

Next to the word, the unit reports whether the result should be read as unsigned or as two's complement. It decides this from the filter's symmetry mode and the separate unsigned/signed settings for data and coefficients. Word, flag and valid strobe are registered together, so the result appears one cycle after the input.

Top module: `fir_out_rounder`

## Requirements
- R1: For position code c in 0..11, a single 1 is added at word bit c+8. That bit has weight 2^(c-10), with bit 18 weighted 2^0. Code 11 adds at bit 19 (2^1) and code 0 adds at bit 8 (2^-10).
- R2: After the add, all bits from bit 0 up to and including the add bit are zero. That leaves 19-c valid MSBs: 8 bits for code 11 and 19 bits for code 0.
- R3: The add wraps modulo 2^28, with no saturation, when it carries out of bit 27.
- R4: Code 9 adds at 2^-1 (bit 17). It gives a 10-bit result in bits 27..18, with bits 17..0 zero.
- R5: Codes 12 to 15 disable rounding. The word passes through unchanged.
- R6: The mode input is encoded as 0 = even symmetric, 1 = odd symmetric, 2 = asymmetric and 3 = decimating. The data and coefficient format inputs are 1 for unsigned and 0 for two's complement. out_uns is 1 only for mode 0 with both format inputs at 1; it is 0 in every other combination.
- R7: An input with in_valid high in one cycle appears on out_word/out_uns with out_valid high after the next rising clock edge. The position code, mode and formats are sampled in that same cycle. out_valid is low after a cycle with in_valid low.
- R8: While in_valid is low, out_word and out_uns hold their last values.
- R9: While reset (rst_n low) is applied, out_valid, out_word and out_uns are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word strobe |
| in_word | input | 28 | Accumulated result, bit 18 = 2^0 |
| rnd_code | input | 4 | Rounding position code |
| filt_mode | input | 2 | Filter symmetry mode |
| data_uns | input | 1 | Data samples are unsigned |
| coef_uns | input | 1 | Coefficients are unsigned |
| out_valid | output | 1 | Output word strobe |
| out_word | output | 28 | Rounded word, low bits cleared |
| out_uns | output | 1 | Output is unsigned (1) or two's complement (0) |

## Verification
The assertions assume that rnd_code, filt_mode and the two format inputs are stable and meaningful only in cycles with in_valid high. They also assume that the output is judged only one cycle after such a cycle. The stimulus changes those inputs only while driving a strobed word. It also deliberately changes in_word and rnd_code during idle cycles, to show they have no effect. Random codes cover all sixteen values, including the unused ones. Directed words near full scale force the wrap-around carry.

// File: rtl/fir_out_rounder_pkg.sv
package fir_out_rounder_pkg;

   typedef enum logic [1:0] {
      FM_EVEN_SYM = 2'd0,
      FM_ODD_SYM  = 2'd1,
      FM_ASYM     = 2'd2,
      FM_DECIM    = 2'd3
   } filt_mode_e;

   localparam int unsigned DEF_WORD_W = 28;
   localparam int unsigned DEF_FRAC_W = 18;
   localparam int unsigned DEF_CODE_W = 4;
   localparam int unsigned DEF_N_POS  = 12;
   localparam int          DEF_MIN_EXP = -10;

endpackage

// File: rtl/rnd_pos_decode.sv
module rnd_pos_decode #(
   parameter int unsigned WORD_W  = 28,
   parameter int unsigned FRAC_W  = 18,
   parameter int unsigned CODE_W  = 4,
   parameter int unsigned N_POS   = 12,
   parameter int          MIN_EXP = -10
) (
   input  logic [CODE_W-1:0] code,
   output logic [WORD_W-1:0] add_vec,
   output logic [WORD_W-1:0] keep_mask
);
   localparam int BASE_BIT = int'(FRAC_W) + MIN_EXP;

   logic pos_ok;
   assign pos_ok = (int'(code) < int'(N_POS));

   for (genvar p = 0; p < WORD_W; p++) begin : g_add
      if (p >= BASE_BIT && p < BASE_BIT + int'(N_POS)) begin : g_sel
         assign add_vec[p] = (code == CODE_W'(p - BASE_BIT));
      end else begin : g_none
         assign add_vec[p] = 1'b0;
      end
   end

   always_comb begin
      for (int j = 0; j < int'(WORD_W); j++) begin
         keep_mask[j] = !(pos_ok && (j <= BASE_BIT + int'(code)));
      end
   end

endmodule

// File: rtl/rnd_apply.sv
module rnd_apply #(
   parameter int unsigned WORD_W   = 28,
   parameter bit          MASK_LOW = 1'b1
) (
   input  logic [WORD_W-1:0] word_in,
   input  logic [WORD_W-1:0] add_vec,
   input  logic [WORD_W-1:0] keep_mask,
   output logic [WORD_W-1:0] word_out
);
   logic [WORD_W-1:0] sum;
   assign sum = word_in + add_vec;

   if (MASK_LOW) begin : g_masked
      assign word_out = sum & keep_mask;
   end else begin : g_raw
      logic unused_mask;
      assign unused_mask = ^keep_mask;
      assign word_out = sum;
   end

endmodule

// File: rtl/fmt_resolve.sv
module fmt_resolve
   import fir_out_rounder_pkg::*;
(
   input  filt_mode_e mode,
   input  logic       data_uns,
   input  logic       coef_uns,
   output logic       res_uns
);
   always_comb begin
      unique case (mode)
         FM_EVEN_SYM: res_uns = data_uns & coef_uns;
         default:     res_uns = 1'b0;
      endcase
   end
endmodule

// File: rtl/fir_out_rounder.sv
module fir_out_rounder
   import fir_out_rounder_pkg::*;
#(
   parameter int unsigned WORD_W   = DEF_WORD_W,
   parameter int unsigned FRAC_W   = DEF_FRAC_W,
   parameter int unsigned CODE_W   = DEF_CODE_W,
   parameter int unsigned N_POS    = DEF_N_POS,
   parameter int          MIN_EXP  = DEF_MIN_EXP,
   parameter bit          MASK_LOW = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [27:0]       in_word,
   input  logic [3:0]        rnd_code,
   input  logic [1:0]        filt_mode,
   input  logic              data_uns,
   input  logic              coef_uns,
   output logic              out_valid,
   output logic [27:0]       out_word,
   output logic              out_uns
);
   localparam int BASE_BIT = int'(FRAC_W) + MIN_EXP;
   localparam int TOP_BIT  = BASE_BIT + int'(N_POS) - 1;

   if (WORD_W != 28 || CODE_W != 4) begin : g_bad_ports
      initial $error("fir_out_rounder: port widths fixed at 28/4");
   end
   if (BASE_BIT < 0 || TOP_BIT >= int'(WORD_W)) begin : g_bad_range
      initial $error("fir_out_rounder: rounding range outside word");
   end
   if (N_POS > (1 << CODE_W)) begin : g_bad_code
      initial $error("fir_out_rounder: code too narrow for positions");
   end

   logic [WORD_W-1:0] add_vec;
   logic [WORD_W-1:0] keep_mask;
   logic [WORD_W-1:0] rounded;
   logic              uns_c;

   rnd_pos_decode #(
      .WORD_W(WORD_W), .FRAC_W(FRAC_W), .CODE_W(CODE_W),
      .N_POS(N_POS), .MIN_EXP(MIN_EXP)
   ) u_dec (
      .code(rnd_code), .add_vec(add_vec), .keep_mask(keep_mask)
   );

   rnd_apply #(.WORD_W(WORD_W), .MASK_LOW(MASK_LOW)) u_apply (
      .word_in(in_word), .add_vec(add_vec), .keep_mask(keep_mask),
      .word_out(rounded)
   );

   fmt_resolve u_fmt (
      .mode(filt_mode_e'(filt_mode)), .data_uns(data_uns),
      .coef_uns(coef_uns), .res_uns(uns_c)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_word  <= '0;
         out_uns   <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_word <= rounded;
            out_uns  <= uns_c;
         end
      end
   end

   AST_ADD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(add_vec)); // R1
   AST_ADD_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (rnd_code >= 4'(N_POS)) |-> (add_vec == '0)); // R5
   AST_HALF_LOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && rnd_code == 4'd9) |=> (out_word[17:0] == '0)); // R4
   AST_UNUSED_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && rnd_code >= 4'(N_POS)) |=> (out_word == $past(in_word))); // R5
   AST_SIGNED_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && filt_mode != 2'd0) |=> !out_uns); // R6
   AST_VALID_LAT: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid); // R7
   AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid); // R7
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(out_word) && $stable(out_uns))); // R8

endmodule

// File: tb/fir_out_rounder_tb_top.sv
module fir_out_rounder_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [27:0] in_word = '0;
   logic [3:0]  rnd_code = '0;
   logic [1:0]  filt_mode = '0;
   logic        data_uns = 1'b0;
   logic        coef_uns = 1'b0;
   logic        out_valid;
   logic [27:0] out_word;
   logic        out_uns;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   fir_out_rounder dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
      .rnd_code(rnd_code), .filt_mode(filt_mode), .data_uns(data_uns),
      .coef_uns(coef_uns), .out_valid(out_valid), .out_word(out_word),
      .out_uns(out_uns)
   );

   function automatic logic [27:0] exp_word(logic [27:0] w, logic [3:0] c);
      logic [27:0] s;
      int b;
      if (c > 4'd11) return w;
      b = int'(c) + 8;
      s = w + (28'd1 << b);
      for (int j = 0; j <= b; j++) s[j] = 1'b0;
      return s;
   endfunction

   function automatic logic exp_uns(logic [1:0] m, logic d, logic k);
      return (m == 2'd0) && d && k;
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic apply(logic [27:0] w, logic [3:0] c, logic [1:0] m,
                        logic d, logic k, string req);
      in_valid = 1'b1; in_word = w; rnd_code = c;
      filt_mode = m; data_uns = d; coef_uns = k;
      @(negedge clk);
      check({req, " R7 valid"}, {31'd0, out_valid}, 32'd1);
      check({req, " word"}, {4'd0, out_word}, {4'd0, exp_word(w, c)});
      check({req, " R6 fmt"}, {31'd0, out_uns}, {31'd0, exp_uns(m, d, k)});
   endtask

   initial begin
      logic [27:0] held_w;
      logic        held_u;
      void'($urandom(32'd4242));
      @(negedge clk);
      @(negedge clk);
      check("R9 valid", {31'd0, out_valid}, 32'd0);
      check("R9 word", {4'd0, out_word}, 32'd0);
      check("R9 fmt", {31'd0, out_uns}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      apply(28'h0000100, 4'd0, 2'd0, 1, 1, "R1 code0 bit8");
      apply(28'h0000000, 4'd11, 2'd1, 0, 0, "R1 code11 bit19");
      apply(28'h00FFFFF, 4'd11, 2'd0, 1, 1, "R2 code11 8 bits");
      apply(28'h01234FF, 4'd0, 2'd2, 1, 1, "R2 code0 19 bits");
      apply(28'hFFFFFFF, 4'd11, 2'd3, 0, 1, "R3 wrap");
      apply(28'h7FE0000, 4'd9, 2'd0, 0, 1, "R3 wrap sign");
      apply(28'h0A5A5A5, 4'd9, 2'd0, 1, 0, "R4 half");
      apply(28'h3FFFF00, 4'd9, 2'd1, 1, 1, "R4 negative");
      apply(28'h1234567, 4'd12, 2'd0, 1, 1, "R5 code12");
      apply(28'hFEDCBA9, 4'd15, 2'd2, 0, 0, "R5 code15");

      for (int m = 0; m < 4; m++)
         for (int f = 0; f < 4; f++)
            apply(28'h0400000, 4'd5, 2'(m), f[0], f[1], "R6 combo");

      held_w = out_word;
      held_u = out_uns;
      in_valid = 1'b0; in_word = 28'h5555555; rnd_code = 4'd3;
      filt_mode = 2'd0; data_uns = ~held_u; coef_uns = ~held_u;
      @(negedge clk);
      check("R7 idle valid", {31'd0, out_valid}, 32'd0);
      check("R8 hold word", {4'd0, out_word}, {4'd0, held_w});
      check("R8 hold fmt", {31'd0, out_uns}, {31'd0, held_u});

      for (int i = 0; i < 400; i++) begin
         logic [27:0] w;
         logic [3:0]  c;
         w = 28'($urandom);
         c = 4'($urandom_range(0, 15));
         apply(w, c, 2'($urandom), 1'($urandom), 1'($urandom), "R1 R2 random");
         if (($urandom % 5) == 0) begin
            held_w = out_word;
            in_valid = 1'b0; in_word = 28'($urandom); rnd_code = 4'($urandom);
            @(negedge clk);
            check("R8 random hold", {4'd0, out_word}, {4'd0, held_w});
         end
      end
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
         end
      join_any
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule